// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the general registers of a small processor that runs in one of four operating modes. Software sees sixteen register numbers. Number 15 is the program counter and is kept elsewhere. Numbers 0 to 14 are backed by physical storage. Which physical register a number reaches depends on the current mode. The interrupt and supervisor modes each own private copies of the stack and link numbers (13 and 14). The fast-interrupt mode owns private copies of numbers 8 to 14, so its handler has spare registers without saving anything. Every other number reaches the shared user register.

There are two combinational read ports and one write port. Each port takes a 4-bit register number and a force-user flag. The flag sends the access to the user bank whatever the mode is, which lets a privileged handler load or store the interrupted program's registers directly. A separate link-write input loads the supervisor copy of register 14 with a return value when a supervisor call is taken, from any mode. A write is seen by a read of the same physical register in the same cycle. Reset leaves the storage untouched.

Top module: `mode_banked_regfile`

## Requirements
- R1: The mode input is coded 0 = user, 1 = fast interrupt, 2 = interrupt, 3 = supervisor. In user mode, numbers 0 to 14 reach the fifteen user registers, and the force-user flag has no effect.
- R2: In interrupt mode and in supervisor mode, numbers 13 and 14 reach a private copy owned by that mode, and numbers 0 to 12 reach the user registers.
- R3: In fast-interrupt mode, numbers 8 to 14 reach seven private fast-interrupt copies, and numbers 0 to 7 reach the user registers.
- R4: A read with its force-user flag set returns the user register for that number in every mode.
- R5: A write with the force-user flag set in a privileged mode updates the user register, and the mode's private copy keeps its value. This is the case of a base register updated by write-back under the force-user option.
- R6: The link-write input loads the supervisor copy of register 14 at the next clock edge, whatever the current mode. If the write port targets that same physical register in the same cycle, the link-write value is stored.
- R7: A write to number 14 without force-user, as a branch-with-link does, updates the link copy of the current mode only.
- R8: Reads are combinational. A write or link-write pending in the current cycle to the physical register being read appears on the read data in that cycle. A write to a different physical register that has the same number is not forwarded.
- R9: Number 15 always reads as zero, and a write to number 15 changes no register.
- R10: Reset changes none of the stored register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Active-low reset; qualifies checks only, storage is not cleared |
| mode | input | 2 | Current operating mode (0 user, 1 fast interrupt, 2 interrupt, 3 supervisor) |
| rd_a_num | input | 4 | Register number for read port A |
| rd_a_usr | input | 1 | Force read port A to the user bank |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_num | input | 4 | Register number for read port B |
| rd_b_usr | input | 1 | Force read port B to the user bank |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_num | input | 4 | Write port register number |
| wr_usr | input | 1 | Force the write to the user bank |
| wr_data | input | DATA_W | Write port data |
| lnk_en | input | 1 | Supervisor-call link-write enable |
| lnk_data | input | DATA_W | Value for the supervisor copy of register 14 |

## Verification
Every physical register is loaded with a value that encodes its own bank and number. A read that reaches the wrong copy therefore shows up as a specific wrong value, not just as a mismatch. The same register numbers are then read in each of the four modes, with and without force-user, which separates a mapping error in the shared range from one in the private range, and the fast-interrupt depth from the interrupt and supervisor depth. Writes under force-user and link-writes from a foreign mode are followed by reads of both the user copy and the private copy, so a write that lands in the wrong bank is told apart from one that lands in both. Same-cycle write-and-read pairs are tried with matching and with differing physical targets behind the same number, which tests forwarding on the physical slot rather than on the register number.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int NUM_W         = 4;
  localparam int NUM_ARCH      = 1 << NUM_W;
  localparam int PC_NUM        = NUM_ARCH - 1;
  localparam int LINK_NUM      = NUM_ARCH - 2;
  localparam int FIQ_BASE_NUM  = 8;
  localparam int PRIV_BASE_NUM = 13;

  localparam int USR_CNT  = NUM_ARCH - 1;
  localparam int FIQ_CNT  = PC_NUM - FIQ_BASE_NUM;
  localparam int PRIV_CNT = PC_NUM - PRIV_BASE_NUM;

  localparam int FIQ_OFS  = USR_CNT;
  localparam int IRQ_OFS  = FIQ_OFS + FIQ_CNT;
  localparam int SVC_OFS  = IRQ_OFS + PRIV_CNT;
  localparam int PHYS_CNT = SVC_OFS + PRIV_CNT;
  localparam int PHYS_W   = $clog2(PHYS_CNT);

  typedef enum logic [1:0] {
    MODE_USR = 2'd0,
    MODE_FIQ = 2'd1,
    MODE_IRQ = 2'd2,
    MODE_SVC = 2'd3
  } mode_e;

  typedef logic [PHYS_W-1:0] phys_t;
  typedef logic [NUM_W-1:0]  num_t;

  typedef struct packed {
    logic  hit;
    phys_t idx;
  } slot_t;

  localparam phys_t SVC_LINK_IDX = phys_t'(SVC_OFS + LINK_NUM - PRIV_BASE_NUM);

  function automatic phys_t bank_offset(num_t num, int base_num, int ofs);
    return phys_t'(ofs) + phys_t'(num) - phys_t'(base_num);
  endfunction

  function automatic slot_t locate(num_t num, mode_e m, logic force_usr);
    slot_t s;
    s.hit = (num != num_t'(PC_NUM));
    s.idx = phys_t'(num);
    if (!force_usr) begin
      unique case (m)
        MODE_FIQ: if (num >= num_t'(FIQ_BASE_NUM))  s.idx = bank_offset(num, FIQ_BASE_NUM, FIQ_OFS);
        MODE_IRQ: if (num >= num_t'(PRIV_BASE_NUM)) s.idx = bank_offset(num, PRIV_BASE_NUM, IRQ_OFS);
        MODE_SVC: if (num >= num_t'(PRIV_BASE_NUM)) s.idx = bank_offset(num, PRIV_BASE_NUM, SVC_OFS);
        default:  s.idx = phys_t'(num);
      endcase
    end
    if (!s.hit) s.idx = '0;
    return s;
  endfunction

endpackage

// File: rtl/rb_locate.sv
module rb_locate
  import regbank_pkg::*;
(
  input  num_t  num,
  input  mode_e mode,
  input  logic  force_usr,
  output slot_t slot
);

  always_comb slot = locate(num, mode, force_usr);

endmodule

// File: rtl/rb_storage.sv
module rb_storage
  import regbank_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int RD_PORTS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              w_en,
  input  phys_t             w_idx,
  input  logic [DATA_W-1:0] w_data,
  input  logic              l_en,
  input  logic [DATA_W-1:0] l_data,
  input  phys_t             r_idx  [RD_PORTS],
  output logic [DATA_W-1:0] r_data [RD_PORTS]
);

  logic [DATA_W-1:0] mem [PHYS_CNT];

  // Link-write is applied last so it wins a collision (R6).
  always_ff @(posedge clk) begin
    if (w_en) mem[w_idx] <= w_data;
    if (l_en) mem[SVC_LINK_IDX] <= l_data;
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign r_data[p] = mem[r_idx[p]];
  end

  logic w_collides;
  assign w_collides = l_en && (w_idx == SVC_LINK_IDX);

  a_r6_link_lands: assert property (@(posedge clk) disable iff (!rst_n)
    l_en |=> mem[SVC_LINK_IDX] == $past(l_data));

  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (w_en && !w_collides) |=> mem[$past(w_idx)] == $past(w_data));

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!w_en && !l_en) |=> $stable(mem[SVC_LINK_IDX]));

endmodule

// File: rtl/rb_fwd.sv
module rb_fwd
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_t             r_slot,
  input  logic [DATA_W-1:0] mem_data,
  input  logic              w_hit,
  input  phys_t             w_idx,
  input  logic [DATA_W-1:0] w_data,
  input  logic              l_en,
  input  logic [DATA_W-1:0] l_data,
  output logic [DATA_W-1:0] r_data
);

  logic l_match, w_match;
  assign l_match = l_en  && (r_slot.idx == SVC_LINK_IDX);
  assign w_match = w_hit && (r_slot.idx == w_idx);

  always_comb begin
    if (!r_slot.hit)  r_data = '0;
    else if (l_match) r_data = l_data;
    else if (w_match) r_data = w_data;
    else              r_data = mem_data;
  end

  // Whatever is shown now must be what the register holds after the edge (R8).
  a_r8_shown_is_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (r_slot.hit && (l_match || w_match)) |=> mem_data == $past(r_data) || $past(r_slot.idx) != r_slot.idx);

endmodule

// File: rtl/mode_banked_regfile.sv
module mode_banked_regfile
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [3:0]        rd_a_num,
  input  logic              rd_a_usr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_num,
  input  logic              rd_b_usr,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_num,
  input  logic              wr_usr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lnk_en,
  input  logic [DATA_W-1:0] lnk_data
);

  localparam int RD_PORTS = 2;

  mode_e cur_mode;
  assign cur_mode = mode_e'(mode);

  num_t              rn      [RD_PORTS];
  logic              ru      [RD_PORTS];
  slot_t             rslot   [RD_PORTS];
  phys_t             ridx    [RD_PORTS];
  logic [DATA_W-1:0] raw     [RD_PORTS];
  logic [DATA_W-1:0] rout    [RD_PORTS];

  assign rn[0] = rd_a_num;  assign ru[0] = rd_a_usr;
  assign rn[1] = rd_b_num;  assign ru[1] = rd_b_usr;

  slot_t wslot;
  logic  w_hit;

  rb_locate u_wloc (.num(wr_num), .mode(cur_mode), .force_usr(wr_usr), .slot(wslot));
  assign w_hit = wr_en && wslot.hit;  // number 15 is dropped here (R9)

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
    rb_locate u_rloc (.num(rn[p]), .mode(cur_mode), .force_usr(ru[p]), .slot(rslot[p]));
    assign ridx[p] = rslot[p].idx;
    rb_fwd #(.DATA_W(DATA_W)) u_fwd (
      .clk(clk), .rst_n(rst_n),
      .r_slot(rslot[p]), .mem_data(raw[p]),
      .w_hit(w_hit), .w_idx(wslot.idx), .w_data(wr_data),
      .l_en(lnk_en), .l_data(lnk_data),
      .r_data(rout[p])
    );
  end

  rb_storage #(.DATA_W(DATA_W), .RD_PORTS(RD_PORTS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .w_en(w_hit), .w_idx(wslot.idx), .w_data(wr_data),
    .l_en(lnk_en), .l_data(lnk_data),
    .r_idx(ridx), .r_data(raw)
  );

  assign rd_a_data = rout[0];
  assign rd_b_data = rout[1];

  a_r9_pc_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_num == 4'(PC_NUM)) |-> rd_a_data == '0);

  a_r1_user_flag_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MODE_USR && rd_a_num == rd_b_num) |-> rd_a_data == rd_b_data);

  a_r2_shared_low_range: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_mode == MODE_IRQ || cur_mode == MODE_SVC) && rd_a_num == rd_b_num
     && rd_a_num < 4'(PRIV_BASE_NUM)) |-> rd_a_data == rd_b_data);

  a_r3_fiq_low_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MODE_FIQ && rd_a_num == rd_b_num
     && rd_a_num < 4'(FIQ_BASE_NUM)) |-> rd_a_data == rd_b_data);

endmodule

// File: tb/sim_mode_banked_regfile.sv
`timescale 1ns/1ps
module sim_mode_banked_regfile;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [3:0]    rd_a_num = '0, rd_b_num = '0, wr_num = '0;
  logic          rd_a_usr = 1'b0, rd_b_usr = 1'b0, wr_usr = 1'b0;
  logic          wr_en = 1'b0, lnk_en = 1'b0;
  logic [DW-1:0] wr_data = '0, lnk_data = '0;
  logic [DW-1:0] rd_a_data, rd_b_data;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  mode_banked_regfile #(.DATA_W(DW)) u0 (.*);

  // Seed values: bank tag in the top byte, register number in the low byte.
  function automatic logic [DW-1:0] seed(logic [7:0] bank, int num);
    return {bank, 16'h0000, 8'(num)};
  endfunction

  task automatic check(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_write(logic [1:0] m, int num, logic usr, logic [DW-1:0] d);
    @(negedge clk);
    mode = m; wr_en = 1'b1; wr_num = 4'(num); wr_usr = usr; wr_data = d;
    @(posedge clk); #0.5;
    wr_en = 1'b0; wr_usr = 1'b0;
  endtask

  task automatic do_link(logic [1:0] m, logic [DW-1:0] d);
    @(negedge clk);
    mode = m; lnk_en = 1'b1; lnk_data = d;
    @(posedge clk); #0.5;
    lnk_en = 1'b0;
  endtask

  // Both ports read the same location; both are checked.
  task automatic read_chk(string req, logic [1:0] m, int num, logic usr, logic [DW-1:0] exp);
    @(negedge clk);
    mode = m; rd_a_num = 4'(num); rd_a_usr = usr; rd_b_num = 4'(num); rd_b_usr = usr;
    #1;
    check(req, rd_a_data, exp);
    check(req, rd_b_data, exp);
  endtask

  task automatic t_fill_user;
    for (int i = 0; i < 15; i++) do_write(2'd0, i, 1'b0, seed(8'hA0, i));
    for (int i = 0; i < 15; i++) read_chk("R1", 2'd0, i, 1'b0, seed(8'hA0, i));
    read_chk("R1", 2'd0, 5, 1'b1, seed(8'hA0, 5));
  endtask

  task automatic t_irq_svc;
    for (int i = 13; i < 15; i++) do_write(2'd2, i, 1'b0, seed(8'hB0, i));
    for (int i = 13; i < 15; i++) do_write(2'd3, i, 1'b0, seed(8'hC0, i));
    read_chk("R2", 2'd2, 13, 1'b0, seed(8'hB0, 13));
    read_chk("R2", 2'd3, 14, 1'b0, seed(8'hC0, 14));
    read_chk("R2", 2'd2, 12, 1'b0, seed(8'hA0, 12));
    read_chk("R2", 2'd3, 8,  1'b0, seed(8'hA0, 8));
    read_chk("R2", 2'd0, 13, 1'b0, seed(8'hA0, 13));
  endtask

  task automatic t_fiq;
    for (int i = 8; i < 15; i++) do_write(2'd1, i, 1'b0, seed(8'hD0, i));
    for (int i = 8; i < 15; i++) read_chk("R3", 2'd1, i, 1'b0, seed(8'hD0, i));
    read_chk("R3", 2'd1, 7,  1'b0, seed(8'hA0, 7));
    read_chk("R3", 2'd0, 8,  1'b0, seed(8'hA0, 8));
    read_chk("R3", 2'd2, 13, 1'b0, seed(8'hB0, 13));
  endtask

  task automatic t_force_read;
    @(negedge clk);
    mode = 2'd1; rd_a_num = 4'd10; rd_a_usr = 1'b1; rd_b_num = 4'd10; rd_b_usr = 1'b0;
    #1;
    check("R4", rd_a_data, seed(8'hA0, 10));
    check("R4", rd_b_data, seed(8'hD0, 10));
    read_chk("R4", 2'd3, 13, 1'b1, seed(8'hA0, 13));
    read_chk("R4", 2'd2, 14, 1'b1, seed(8'hA0, 14));
  endtask

  task automatic t_force_write;
    do_write(2'd2, 13, 1'b1, 32'hE000_0013);
    read_chk("R5", 2'd2, 13, 1'b0, seed(8'hB0, 13));
    read_chk("R5", 2'd2, 13, 1'b1, 32'hE000_0013);
    read_chk("R5", 2'd0, 13, 1'b0, 32'hE000_0013);
    do_write(2'd1, 9, 1'b1, 32'hE000_0009);
    read_chk("R5", 2'd1, 9, 1'b0, seed(8'hD0, 9));
    read_chk("R5", 2'd0, 9, 1'b0, 32'hE000_0009);
  endtask

  task automatic t_branch_link;
    do_write(2'd2, 14, 1'b0, 32'hF000_0214);
    read_chk("R7", 2'd2, 14, 1'b0, 32'hF000_0214);
    read_chk("R7", 2'd3, 14, 1'b0, seed(8'hC0, 14));
    read_chk("R7", 2'd1, 14, 1'b0, seed(8'hD0, 14));
    read_chk("R7", 2'd0, 14, 1'b0, seed(8'hA0, 14));
  endtask

  task automatic t_svc_link;
    do_link(2'd0, 32'h5500_0001);
    read_chk("R6", 2'd3, 14, 1'b0, 32'h5500_0001);
    read_chk("R6", 2'd0, 14, 1'b0, seed(8'hA0, 14));
    read_chk("R6", 2'd2, 14, 1'b0, 32'hF000_0214);
    // Collision on the supervisor link copy: link value wins.
    @(negedge clk);
    mode = 2'd3; wr_en = 1'b1; wr_num = 4'd14; wr_data = 32'h6600_0000;
    lnk_en = 1'b1; lnk_data = 32'h7700_0000;
    @(posedge clk); #0.5;
    wr_en = 1'b0; lnk_en = 1'b0;
    read_chk("R6", 2'd3, 14, 1'b0, 32'h7700_0000);
    // Link from fast-interrupt mode with a port write to its own link copy: both land.
    @(negedge clk);
    mode = 2'd1; wr_en = 1'b1; wr_num = 4'd14; wr_data = 32'h6600_0001;
    lnk_en = 1'b1; lnk_data = 32'h7700_0001;
    @(posedge clk); #0.5;
    wr_en = 1'b0; lnk_en = 1'b0;
    read_chk("R6", 2'd1, 14, 1'b0, 32'h6600_0001);
    read_chk("R6", 2'd3, 14, 1'b0, 32'h7700_0001);
  endtask

  task automatic t_forward;
    @(negedge clk);
    mode = 2'd1; wr_en = 1'b1; wr_num = 4'd11; wr_usr = 1'b0; wr_data = 32'h1234_5678;
    rd_a_num = 4'd11; rd_a_usr = 1'b0; rd_b_num = 4'd11; rd_b_usr = 1'b1;
    #1;
    check("R8", rd_a_data, 32'h1234_5678);
    check("R8", rd_b_data, seed(8'hA0, 11));
    @(posedge clk); #0.5;
    wr_en = 1'b0;
    @(negedge clk);
    mode = 2'd0; lnk_en = 1'b1; lnk_data = 32'h9ABC_DEF0;
    rd_a_num = 4'd14; rd_a_usr = 1'b0; rd_b_num = 4'd14; rd_b_usr = 1'b0;
    mode = 2'd3;
    #1;
    check("R8", rd_a_data, 32'h9ABC_DEF0);
    @(posedge clk); #0.5;
    lnk_en = 1'b0;
    read_chk("R8", 2'd1, 11, 1'b0, 32'h1234_5678);
  endtask

  task automatic t_pc_slot;
    read_chk("R9", 2'd0, 15, 1'b0, '0);
    do_write(2'd3, 15, 1'b0, 32'hDEAD_BEEF);
    read_chk("R9", 2'd3, 15, 1'b0, '0);
    read_chk("R9", 2'd0, 14, 1'b0, seed(8'hA0, 14));
    read_chk("R9", 2'd0, 0,  1'b0, seed(8'hA0, 0));
    read_chk("R9", 2'd3, 14, 1'b0, 32'h9ABC_DEF0);
  endtask

  task automatic t_reset_keeps;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    read_chk("R10", 2'd0, 3, 1'b0, seed(8'hA0, 3));
    read_chk("R10", 2'd1, 12, 1'b0, seed(8'hD0, 12));
    read_chk("R10", 2'd2, 13, 1'b0, seed(8'hB0, 13));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_fill_user();
    t_irq_svc();
    t_fiq();
    t_force_read();
    t_force_write();
    t_branch_link();
    t_svc_link();
    t_forward();
    t_pc_slot();
    t_reset_keeps();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule